// File: doc/BRIEF.md
# ALU with Zero and Carry Flags

This block is the execution unit of a small 16-bit RISC core. It performs add, subtract, AND, OR and XOR, the compare and test forms of those operations, register and immediate moves, and the zero-flag update for a load. It takes two 16-bit operands, a 4-bit operation code, an immediate field with its selection controls, and a flag-write-enable. It returns a result, a flag telling whether that result is written back, and the next values of the zero and carry flags.

The result, the write flag and the next-flag values are combinational, so they are valid in the same cycle as the inputs. The zero and carry flags themselves sit in a register. That register loads the next values on a rising clock edge only when the flag-write-enable is high, and reset clears it. The block chooses the second operand: either the register operand, or a zero-extended short immediate whose width depends on whether the instruction is conditional. It also sign-extends the wider immediate used by the immediate move.

Top module: `alu_flags_unit`

## Requirements
- R1: The op_i codes are ADD=0, SUB=1, AND=2, OR=3, XOR=4, CMN=5, CMP=6, TSTAND=7, TSTOR=8, TSTXOR=9, MOVR=10, MOVI=11, LOAD=12. ADD gives b+opnd, SUB gives b-opnd, and AND, OR and XOR give the bitwise result of b and opnd. All five set result_we_o to 1.
- R2: For ADD and CMN, carry is the carry out of bit 15. For SUB and CMP, carry is 1 exactly when b is greater than or equal to opnd, both taken as unsigned.
- R3: AND, OR and XOR update zero only. Their next carry equals the current carry.
- R4: CMN (b+opnd), CMP (b-opnd), TSTAND, TSTOR and TSTXOR place their value on result_o with result_we_o at 0. CMN and CMP update zero and carry. The three test forms update zero only.
- R5: Wherever zero is updated, it is 1 exactly when the 16-bit result is 0x0000.
- R6: When use_imm_i is 1, opnd is imm_i[3:0] zero-extended. For ops 0 to 4 with cond_i at 1, opnd is imm_i[2:0] zero-extended instead. Compare and test ops always use imm_i[3:0]. When use_imm_i is 0, opnd is a_i.
- R7: MOVR gives result a_i and ignores use_imm_i. It writes the result, sets zero from the value and keeps carry.
- R8: MOVI gives imm_i[8:0] sign-extended, or imm_i[6:0] sign-extended when cond_i is 1. It writes the result and leaves both flags unchanged.
- R9: LOAD gives result a_i (the loaded data) with result_we_o at 1. It sets zero from a_i and keeps carry.
- R10: zero_q_o and carry_q_o load zero_d_o and carry_d_o on a rising edge when flag_we_i is 1, hold their value otherwise, and are both 0 after reset.
- R11: Codes 13 to 15 give result 0 and result_we_o at 0, and the next flags equal the current flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 4 | Operation code |
| b_i | input | 16 | First operand (Rb, or Rd for compare/test) |
| a_i | input | 16 | Register operand, or loaded data for LOAD |
| imm_i | input | 9 | Immediate field |
| use_imm_i | input | 1 | Selects the immediate as the second operand |
| cond_i | input | 1 | Instruction is conditional (narrows immediates) |
| flag_we_i | input | 1 | Lets the flags update at the next edge |
| result_o | output | 16 | Operation result |
| result_we_o | output | 1 | Result is written back |
| zero_d_o | output | 1 | Next zero flag |
| carry_d_o | output | 1 | Next carry flag |
| zero_q_o | output | 1 | Registered zero flag |
| carry_q_o | output | 1 | Registered carry flag |

## Verification
The result, the write flag and the next-flag outputs have no register in their path, so they are due in the same cycle as the inputs. The bench drives inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. The registered flags are due one rising edge later, so the bench samples them one nanosecond after that edge and compares them with a model that loads only when flag_we_i was high. Reset is checked both from power-up and after the flags have been set.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_CMN   = 4'd5,
        OP_CMP   = 4'd6,
        OP_TAND  = 4'd7,
        OP_TOR   = 4'd8,
        OP_TXOR  = 4'd9,
        OP_MOVR  = 4'd10,
        OP_MOVI  = 4'd11,
        OP_LOAD  = 4'd12,
        OP_RSV13 = 4'd13,
        OP_RSV14 = 4'd14,
        OP_RSV15 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic wr;
        logic upd_z;
        logic upd_c;
        logic cmp_class;
    } op_ctl_t;

    function automatic op_ctl_t decode_op(input logic [3:0] op);
        op_ctl_t c;
        c = '0;
        unique case (alu_op_e'(op))
            OP_ADD, OP_SUB:           begin c.wr = 1'b1; c.upd_z = 1'b1; c.upd_c = 1'b1; end
            OP_AND, OP_OR, OP_XOR:    begin c.wr = 1'b1; c.upd_z = 1'b1; end
            OP_CMN, OP_CMP:           begin c.upd_z = 1'b1; c.upd_c = 1'b1; c.cmp_class = 1'b1; end
            OP_TAND, OP_TOR, OP_TXOR: begin c.upd_z = 1'b1; c.cmp_class = 1'b1; end
            OP_MOVR, OP_LOAD:         begin c.wr = 1'b1; c.upd_z = 1'b1; end
            OP_MOVI:                  begin c.wr = 1'b1; end
            default:                  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_opsel.sv
module alu_opsel
    import alu_pkg::*;
#(
    parameter int DW         = 16,
    parameter int IMM_W      = 4,
    parameter int IMM_COND_W = 3,
    parameter int MOV_W      = 9,
    parameter int MOV_COND_W = 7
) (
    input  logic [DW-1:0]    a_i,
    input  logic [MOV_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             cond_i,
    input  logic             cmp_class_i,
    output logic [DW-1:0]    opnd_o,
    output logic [DW-1:0]    mov_val_o
);

    localparam int EXT_FULL = DW - IMM_W;
    localparam int EXT_COND = DW - IMM_COND_W;
    localparam int SX_FULL  = DW - MOV_W;
    localparam int SX_COND  = DW - MOV_COND_W;

    typedef struct packed {
        logic [DW-1:0] opnd;
        logic [DW-1:0] mov;
    } sel_t;

    sel_t sel_d;

    always_comb begin
        sel_d = '0;
        if (!use_imm_i) begin
            sel_d.opnd = a_i;
        end else if (cond_i && !cmp_class_i) begin
            sel_d.opnd = {{EXT_COND{1'b0}}, imm_i[IMM_COND_W-1:0]};
        end else begin
            sel_d.opnd = {{EXT_FULL{1'b0}}, imm_i[IMM_W-1:0]};
        end

        if (cond_i) begin
            sel_d.mov = {{SX_COND{imm_i[MOV_COND_W-1]}}, imm_i[MOV_COND_W-1:0]};
        end else begin
            sel_d.mov = {{SX_FULL{imm_i[MOV_W-1]}}, imm_i};
        end
    end

    assign opnd_o    = sel_d.opnd;
    assign mov_val_o = sel_d.mov;

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] b_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] opnd_i,
    input  logic [DW-1:0] mov_val_i,
    input  logic          zero_q_i,
    input  logic          carry_q_i,
    output logic [DW-1:0] result_o,
    output logic          result_we_o,
    output logic          zero_d_o,
    output logic          carry_d_o
);

    typedef struct packed {
        logic [DW-1:0] res;
        logic          wr;
        logic          z;
        logic          c;
    } dp_t;

    op_ctl_t     ctl;
    logic [DW:0] sum_w;
    logic [DW:0] dif_w;
    dp_t         dp_d;

    always_comb begin
        ctl   = decode_op(op_i);
        sum_w = {1'b0, b_i} + {1'b0, opnd_i};
        dif_w = {1'b0, b_i} - {1'b0, opnd_i};
        dp_d     = '0;
        dp_d.wr  = ctl.wr;
        unique case (alu_op_e'(op_i))
            OP_ADD, OP_CMN:  dp_d.res = sum_w[DW-1:0];
            OP_SUB, OP_CMP:  dp_d.res = dif_w[DW-1:0];
            OP_AND, OP_TAND: dp_d.res = b_i & opnd_i;
            OP_OR,  OP_TOR:  dp_d.res = b_i | opnd_i;
            OP_XOR, OP_TXOR: dp_d.res = b_i ^ opnd_i;
            OP_MOVR, OP_LOAD: dp_d.res = a_i;
            OP_MOVI:         dp_d.res = mov_val_i;
            default:         dp_d.res = '0;
        endcase

        dp_d.z = ctl.upd_z ? (dp_d.res == '0) : zero_q_i;

        if (!ctl.upd_c) begin
            dp_d.c = carry_q_i;
        end else if (op_i == OP_ADD || op_i == OP_CMN) begin
            dp_d.c = sum_w[DW];
        end else begin
            dp_d.c = ~dif_w[DW];
        end
    end

    assign result_o    = dp_d.res;
    assign result_we_o = dp_d.wr;
    assign zero_d_o    = dp_d.z;
    assign carry_d_o   = dp_d.c;

endmodule

// File: rtl/alu_flagreg.sv
module alu_flagreg (
    input  logic clk,
    input  logic rst_n,
    input  logic we_i,
    input  logic zero_d_i,
    input  logic carry_d_i,
    output logic zero_q_o,
    output logic carry_q_o
);

    typedef struct packed {
        logic z;
        logic c;
    } flags_t;

    flags_t flags_d;
    flags_t flags_q;

    always_comb begin
        flags_d = flags_q;
        if (we_i) begin
            flags_d.z = zero_d_i;
            flags_d.c = carry_d_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign zero_q_o  = flags_q.z;
    assign carry_q_o = flags_q.c;

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_pkg::*;
#(
    parameter int DW         = DATA_W,
    parameter int IMM_W      = 4,
    parameter int IMM_COND_W = 3,
    parameter int MOV_W      = 9,
    parameter int MOV_COND_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       op_i,
    input  logic [DW-1:0]    b_i,
    input  logic [DW-1:0]    a_i,
    input  logic [MOV_W-1:0] imm_i,
    input  logic             use_imm_i,
    input  logic             cond_i,
    input  logic             flag_we_i,
    output logic [DW-1:0]    result_o,
    output logic             result_we_o,
    output logic             zero_d_o,
    output logic             carry_d_o,
    output logic             zero_q_o,
    output logic             carry_q_o
);

    op_ctl_t       ctl;
    logic [DW-1:0] opnd;
    logic [DW-1:0] mov_val;

    assign ctl = decode_op(op_i);

    alu_opsel #(
        .DW(DW), .IMM_W(IMM_W), .IMM_COND_W(IMM_COND_W),
        .MOV_W(MOV_W), .MOV_COND_W(MOV_COND_W)
    ) u_opsel (
        .a_i         (a_i),
        .imm_i       (imm_i),
        .use_imm_i   (use_imm_i),
        .cond_i      (cond_i),
        .cmp_class_i (ctl.cmp_class),
        .opnd_o      (opnd),
        .mov_val_o   (mov_val)
    );

    alu_datapath #(.DW(DW)) u_dp (
        .op_i        (op_i),
        .b_i         (b_i),
        .a_i         (a_i),
        .opnd_i      (opnd),
        .mov_val_i   (mov_val),
        .zero_q_i    (zero_q_o),
        .carry_q_i   (carry_q_o),
        .result_o    (result_o),
        .result_we_o (result_we_o),
        .zero_d_o    (zero_d_o),
        .carry_d_o   (carry_d_o)
    );

    alu_flagreg u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (flag_we_i),
        .zero_d_i  (zero_d_o),
        .carry_d_i (carry_d_o),
        .zero_q_o  (zero_q_o),
        .carry_q_o (carry_q_o)
    );

endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_i,
    input logic [DW-1:0] a_i,
    input logic          flag_we_i,
    input logic [DW-1:0] result_o,
    input logic          result_we_o,
    input logic          zero_d_o,
    input logic          carry_d_o,
    input logic          zero_q_o,
    input logic          carry_q_o
);

    logic is_alu_wr, is_cmp, is_logic, is_zupd;
    assign is_alu_wr = (op_i <= 4'd4) || (op_i >= 4'd10 && op_i <= 4'd12);
    assign is_cmp    = (op_i >= 4'd5) && (op_i <= 4'd9);
    assign is_logic  = (op_i >= 4'd2) && (op_i <= 4'd4);
    assign is_zupd   = (op_i <= 4'd10) || (op_i == 4'd12);

    AST_WRITE_OPS: assert property (@(posedge clk) disable iff (!rst_n)
        is_alu_wr |-> result_we_o); // R1

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmp |-> !result_we_o); // R4

    AST_LOGIC_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |-> (carry_d_o == carry_q_o)); // R3

    AST_ZERO_FROM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        is_zupd |-> (zero_d_o == (result_o == '0))); // R5

    AST_MOVI_FLAGS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd11) |-> (zero_d_o == zero_q_o && carry_d_o == carry_q_o)); // R8

    AST_LOAD_PASSES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd12) |-> (result_o == a_i)); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> ($stable(zero_q_o) && $stable(carry_q_o))); // R10

    AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> (zero_q_o == $past(zero_d_o) && carry_q_o == $past(carry_d_o))); // R10

    AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i >= 4'd13) |-> (!result_we_o && zero_d_o == zero_q_o && carry_d_o == carry_q_o)); // R11

endmodule

bind alu_flags_unit alu_flags_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .a_i         (a_i),
    .flag_we_i   (flag_we_i),
    .result_o    (result_o),
    .result_we_o (result_we_o),
    .zero_d_o    (zero_d_o),
    .carry_d_o   (carry_d_o),
    .zero_q_o    (zero_q_o),
    .carry_q_o   (carry_q_o)
);

// File: tb/tb_alu_flags_unit.sv
`timescale 1ns/1ps
module tb_alu_flags_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [15:0] b_i = '0, a_i = '0;
    logic [8:0]  imm_i = '0;
    logic        use_imm_i = 1'b0, cond_i = 1'b0, flag_we_i = 1'b0;
    logic [15:0] result_o;
    logic        result_we_o, zero_d_o, carry_d_o, zero_q_o, carry_q_o;

    int checks = 0;
    int fails  = 0;
    logic mz = 1'b0, mc = 1'b0;

    always #2.5 clk = ~clk;

    alu_flags_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .b_i(b_i), .a_i(a_i),
        .imm_i(imm_i), .use_imm_i(use_imm_i), .cond_i(cond_i),
        .flag_we_i(flag_we_i), .result_o(result_o), .result_we_o(result_we_o),
        .zero_d_o(zero_d_o), .carry_d_o(carry_d_o),
        .zero_q_o(zero_q_o), .carry_q_o(carry_q_o)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [15:0] b;
        logic [15:0] a;
        logic [8:0]  imm;
        logic        ui;
        logic        cd;
        logic [15:0] res;
        logic        we;
        logic        uz;
        logic        uc;
        logic        z;
        logic        c;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h0001, 16'h0002, 9'h000, 1'b0, 1'b0, 16'h0003, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R1 R2 add
        '{4'd0,  16'hFFFF, 16'h0001, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}, // R2 R5 wrap
        '{4'd2,  16'hF0F0, 16'h0F0F, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 and
        '{4'd3,  16'h1200, 16'h0034, 9'h000, 1'b0, 1'b0, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3 or
        '{4'd4,  16'hAAAA, 16'hAAAA, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 xor
        '{4'd1,  16'h0005, 16'h0003, 9'h000, 1'b0, 1'b0, 16'h0002, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R2 sub no borrow
        '{4'd1,  16'h0003, 16'h0005, 9'h000, 1'b0, 1'b0, 16'hFFFE, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 sub borrow
        '{4'd1,  16'h0010, 16'hFFFF, 9'h01F, 1'b1, 1'b0, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 imm 4 bit
        '{4'd0,  16'h0010, 16'hFFFF, 9'h00F, 1'b1, 1'b1, 16'h0017, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R6 imm 3 bit
        '{4'd6,  16'h0007, 16'h0007, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 cmp
        '{4'd5,  16'h8000, 16'h8000, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R4 cmn
        '{4'd7,  16'h00FF, 16'h0F00, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 tst and
        '{4'd8,  16'h0001, 16'h0000, 9'h000, 1'b0, 1'b0, 16'h0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4 tst or
        '{4'd9,  16'h5555, 16'h5555, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R4 tst xor
        '{4'd6,  16'h000F, 16'h0000, 9'h00F, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}, // R6 cmp keeps 4 bit
        '{4'd1,  16'h0000, 16'h0001, 9'h000, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 clear carry
        '{4'd10, 16'h1234, 16'h0000, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 movr zero
        '{4'd10, 16'h0000, 16'h1234, 9'h005, 1'b1, 1'b0, 16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R7 imm ignored
        '{4'd11, 16'h0000, 16'h0000, 9'h1FF, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 -1
        '{4'd11, 16'h0000, 16'h0000, 9'h0C0, 1'b1, 1'b1, 16'hFFC0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 cond -64
        '{4'd11, 16'h0000, 16'h0000, 9'h0FF, 1'b0, 1'b0, 16'h00FF, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 255
        '{4'd12, 16'h0000, 16'h0000, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, // R9 load zero
        '{4'd12, 16'hFFFF, 16'h8001, 9'h000, 1'b0, 1'b0, 16'h8001, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R9 load nonzero
        '{4'd2,  16'h00FF, 16'h0000, 9'h00F, 1'b1, 1'b1, 16'h0007, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 and imm cond
        '{4'd13, 16'h1234, 16'h1234, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R11
        '{4'd15, 16'h0000, 16'h0000, 9'h000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}  // R11
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [15:0] b, input logic [15:0] a,
                         input logic [8:0] imm, input logic ui, input logic cd, input logic fwe);
        op_i = op; b_i = b; a_i = a; imm_i = imm; use_imm_i = ui; cond_i = cd; flag_we_i = fwe;
    endtask

    initial begin
        #(5 * 50000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset zero", {15'd0, zero_q_o}, 16'd0);
        check("R10 reset carry", {15'd0, carry_q_o}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            logic ez, ec;
            v = VECS[i];
            @(negedge clk);
            drive(v.op, v.b, v.a, v.imm, v.ui, v.cd, 1'b1);
            #1;
            ez = v.uz ? v.z : mz;
            ec = v.uc ? v.c : mc;
            check($sformatf("R1-vec%0d result", i), result_o, v.res);
            check($sformatf("R4 vec%0d write", i), {15'd0, result_we_o}, {15'd0, v.we});
            check($sformatf("R5 vec%0d zero_d", i), {15'd0, zero_d_o}, {15'd0, ez});
            check($sformatf("R2 vec%0d carry_d", i), {15'd0, carry_d_o}, {15'd0, ec});
            @(posedge clk);
            #1;
            mz = ez; mc = ec;
            check($sformatf("R10 vec%0d zero_q", i), {15'd0, zero_q_o}, {15'd0, mz});
            check($sformatf("R10 vec%0d carry_q", i), {15'd0, carry_q_o}, {15'd0, mc});
        end

        // R10: flags hold when write-enable is low
        @(negedge clk);
        drive(4'd0, 16'hFFFF, 16'h0001, 9'h000, 1'b0, 1'b0, 1'b0);
        #1;
        check("R10 hold zero_d", {15'd0, zero_d_o}, 16'd1);
        @(posedge clk);
        #1;
        check("R10 hold zero_q", {15'd0, zero_q_o}, {15'd0, mz});
        check("R10 hold carry_q", {15'd0, carry_q_o}, {15'd0, mc});

        // set both flags, then reset mid-run
        @(negedge clk);
        drive(4'd6, 16'h0003, 16'h0003, 9'h000, 1'b0, 1'b0, 1'b1);
        @(posedge clk);
        #1;
        check("R10 set zero", {15'd0, zero_q_o}, 16'd1);
        check("R10 set carry", {15'd0, carry_q_o}, 16'd1);
        @(negedge clk);
        flag_we_i = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R10 reset clears zero", {15'd0, zero_q_o}, 16'd0);
        check("R10 reset clears carry", {15'd0, carry_q_o}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: logic op keeps carry at 1 after carry set
        @(negedge clk);
        drive(4'd0, 16'hFFFF, 16'h0002, 9'h000, 1'b0, 1'b0, 1'b1);
        @(posedge clk);
        @(negedge clk);
        drive(4'd4, 16'h0F00, 16'h00F0, 9'h000, 1'b0, 1'b0, 1'b1);
        #1;
        check("R3 xor result", result_o, 16'h0FF0);
        check("R3 xor keeps carry", {15'd0, carry_d_o}, 16'd1);
        check("R5 xor zero", {15'd0, zero_d_o}, 16'd0);

        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule